// File: doc/BRIEF.md
# Endpoint Handshake Response Selector

This block picks the handshake that one device endpoint returns after each host data transaction. It tracks how many packet slots of the endpoint's buffer are in use. The buffer has one slot, or two when double buffering is enabled. From that count and the controls it answers ACK, NAK, NYET or STALL, or it answers nothing. It also raises an interrupt pulse each time a packet enters the buffer from the bus or leaves it for the bus.

A bus-side decoder presents one event per transaction. The event is a single-cycle strobe that carries the transfer type, the direction as the host sees it, and an ok flag. For OUT the ok flag means the data arrived complete with a good CRC. For IN it means the host acknowledged the data it received. Firmware uses a slot strobe. On an OUT endpoint the strobe frees a slot that firmware has read. On an IN endpoint it fills a slot with a packet waiting to be sent. The response is registered and appears one clock after the event.

Codes: none = 0, ACK = 1, NAK = 2, NYET = 3, STALL = 4. Transfer types: control = 0, isochronous = 1, bulk = 2, interrupt = 3. The direction bit is 1 for IN (device to host) and 0 for OUT (host to device).

Top module: `ep_handshake_sel`

## Requirements
- R1: After reset the slot count is 0, and `hs_valid` and `irq` are low.
- R2: While `stall_req` is high, every non-isochronous event is answered with STALL (code 4) and the slot count does not change.
- R3: An event whose direction differs from `cfg_dir_in` is answered with STALL (code 4). When parameter `EP_NUM` is 0, any non-control event is also answered with STALL; a control event there is handled normally.
- R4: An isochronous event (type 1) gets code none (0) with `hs_valid` high. If it is ok and a slot is available, it still fills a slot (OUT) or empties one (IN) and raises the interrupt.
- R5: An event with the ok flag low gets code none (0). It leaves the slot count unchanged and raises no interrupt.
- R6: An ok OUT event at full speed (`high_speed` = 0) with a free slot takes the slot and is answered with ACK (code 1).
- R7: An ok OUT event that arrives when every slot is full is answered with NAK (code 2). The count is unchanged and no interrupt is raised.
- R8: At high speed, an accepted OUT packet is answered with NYET (code 3) when the resulting count equals the slot total. A firmware release in the same cycle is counted before this test. Otherwise the answer is ACK.
- R9: The slot total is 2 when `dbl_buf_en` is 1 and 1 when it is 0.
- R10: An ok IN event is answered with NAK (code 2) when no slot holds a packet. Otherwise it is answered with ACK (code 1) and empties one slot.
- R11: `irq` pulses for one cycle, one clock after a slot is filled or emptied by a bus event. It pulses only if `int_en` was high at that event.
- R12: `fw_slot` frees a slot on an OUT endpoint and fills a slot on an IN endpoint. It is ignored when there is nothing to free or no room to fill. Both the firmware action and the bus event are judged on the count from before the cycle, and both apply in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | Endpoint direction: 1 = IN, 0 = OUT |
| dbl_buf_en | input | 1 | 1 = two slots, 0 = one slot |
| high_speed | input | 1 | Bus runs at high speed |
| stall_req | input | 1 | Firmware stall request |
| int_en | input | 1 | Endpoint interrupt enable |
| ev_valid | input | 1 | One-cycle transaction event strobe |
| ev_type | input | 2 | Transfer type of the event |
| ev_dir_in | input | 1 | Event direction: 1 = IN |
| ev_ok | input | 1 | OUT: data complete with good CRC; IN: host acknowledged |
| fw_slot | input | 1 | Firmware slot release (OUT) or fill (IN) strobe |
| hs_valid | output | 1 | Response valid, one clock after the event |
| hs_code | output | 3 | Handshake code |
| irq | output | 1 | Endpoint interrupt pulse |
| buf_level | output | 2 | Slots currently in use |

## Verification
Two things can land on the same clock edge: a bus event and a firmware slot strobe. On an OUT endpoint, one packet arrives while firmware frees another. On an IN endpoint, firmware loads a slot while the host drains one. The bench forces this by asserting `fw_slot` in the same cycle as the event, both with a full buffer and with a partly filled one. It then checks three things against rules worked out from the requirements: the code (NAK decided on the count from before the cycle, and ACK rather than NYET once the release is counted), the interrupt, and the final `buf_level`.

// File: rtl/ep_handshake_sel.sv
module ep_handshake_sel #(
  parameter int EP_NUM = 1,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dir_in,
  input  logic             dbl_buf_en,
  input  logic             high_speed,
  input  logic             stall_req,
  input  logic             int_en,
  input  logic             ev_valid,
  input  logic [1:0]       ev_type,
  input  logic             ev_dir_in,
  input  logic             ev_ok,
  input  logic             fw_slot,
  output logic             hs_valid,
  output logic [2:0]       hs_code,
  output logic             irq,
  output logic [CNT_W-1:0] buf_level
);

  localparam logic [2:0] HS_NONE  = 3'd0;
  localparam logic [2:0] HS_ACK   = 3'd1;
  localparam logic [2:0] HS_NAK   = 3'd2;
  localparam logic [2:0] HS_NYET  = 3'd3;
  localparam logic [2:0] HS_STALL = 3'd4;
  localparam logic [1:0] TY_CTRL  = 2'd0;
  localparam logic [1:0] TY_ISO   = 2'd1;

  logic [CNT_W-1:0] count, slots, count_nx;
  logic             full, empty, is_iso, blocked, take, give, fw_up, fw_dn;
  logic [2:0]       code_nx;

  assign slots   = dbl_buf_en ? CNT_W'(2) : CNT_W'(1);
  assign full    = count >= slots;
  assign empty   = count == '0;
  assign is_iso  = ev_type == TY_ISO;
  assign blocked = stall_req || (ev_dir_in != cfg_dir_in) ||
                   ((EP_NUM == 0) && (ev_type != TY_CTRL));

  assign take  = ev_valid && !blocked && ev_ok && !cfg_dir_in && !full;
  assign give  = ev_valid && !blocked && ev_ok &&  cfg_dir_in && !empty;
  assign fw_up = fw_slot &&  cfg_dir_in && !full;
  assign fw_dn = fw_slot && !cfg_dir_in && !empty;

  assign count_nx = count + CNT_W'(take) + CNT_W'(fw_up)
                          - CNT_W'(give) - CNT_W'(fw_dn);

  always_comb begin
    code_nx = HS_NONE;
    if (is_iso)           code_nx = HS_NONE;
    else if (blocked)     code_nx = HS_STALL;
    else if (!ev_ok)      code_nx = HS_NONE;
    else if (!cfg_dir_in) begin
      if (full)           code_nx = HS_NAK;
      else if (high_speed && count_nx == slots) code_nx = HS_NYET;
      else                code_nx = HS_ACK;
    end else begin
      if (empty)          code_nx = HS_NAK;
      else                code_nx = HS_ACK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      irq      <= 1'b0;
    end else begin
      count    <= count_nx;
      hs_valid <= ev_valid;
      hs_code  <= ev_valid ? code_nx : HS_NONE;
      irq      <= int_en && (take || give);
    end
  end

  assign buf_level = count;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(2));

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && stall_req && !is_iso |=> hs_code == HS_STALL && !irq);

  assert_full_nak_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !is_iso && !blocked && ev_ok && !cfg_dir_in && full
    |=> hs_code == HS_NAK && !irq);

  assert_bad_crc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ok && !fw_slot |=> count == $past(count) && !irq);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !irq);

  assert_iso_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && is_iso |=> hs_valid && hs_code == HS_NONE);

endmodule

// File: tb/ep_handshake_sel_test.sv
module ep_handshake_sel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dir_in = 0, dbl_buf_en = 0, high_speed = 0, stall_req = 0, int_en = 1;
  logic ev_valid = 0, ev_dir_in = 0, ev_ok = 0, fw_slot = 0;
  logic [1:0] ev_type = 2'd2;
  logic hs_valid, irq, hs_valid0, irq0;
  logic [2:0] hs_code, hs_code0;
  logic [1:0] buf_level, buf_level0;
  int checks = 0, errors = 0;
  logic [2:0] r_code; logic r_hv, r_irq; logic [1:0] r_lvl; logic [2:0] r0_code;

  always #4 clk = ~clk;

  ep_handshake_sel #(.EP_NUM(1)) uut (.clk, .rst_n, .cfg_dir_in, .dbl_buf_en, .high_speed,
    .stall_req, .int_en, .ev_valid, .ev_type, .ev_dir_in, .ev_ok, .fw_slot,
    .hs_valid, .hs_code, .irq, .buf_level);

  ep_handshake_sel #(.EP_NUM(0)) uut_ep0 (.clk, .rst_n, .cfg_dir_in, .dbl_buf_en, .high_speed,
    .stall_req, .int_en, .ev_valid, .ev_type, .ev_dir_in, .ev_ok, .fw_slot,
    .hs_valid(hs_valid0), .hs_code(hs_code0), .irq(irq0), .buf_level(buf_level0));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] ty, input logic din,
                       input logic ok, input logic fw);
    @(negedge clk);
    ev_valid = v; ev_type = ty; ev_dir_in = din; ev_ok = ok; fw_slot = fw;
    @(negedge clk);
    r_hv = hs_valid; r_code = hs_code; r_irq = irq; r_lvl = buf_level; r0_code = hs_code0;
    ev_valid = 0; fw_slot = 0; ev_ok = 0;
  endtask

  task automatic expect_resp(input string tag, input int code, input int irqv, input int lvl);
    chk({tag, " hs_valid"}, r_hv, 1);
    chk({tag, " code"}, r_code, code);
    chk({tag, " irq"}, r_irq, irqv);
    chk({tag, " level"}, r_lvl, lvl);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 level", buf_level, 0);
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_out_single;
    cfg_dir_in = 0; dbl_buf_en = 0; high_speed = 0; int_en = 1;
    drive(1, 2, 0, 1, 0); expect_resp("R6 ack", 1, 1, 1);
    drive(1, 2, 0, 1, 0); expect_resp("R7 nak full", 2, 0, 1);
    drive(0, 2, 0, 0, 1); chk("R12 release", r_lvl, 0);
    drive(0, 2, 0, 0, 1); chk("R12 release empty ignored", r_lvl, 0);
  endtask

  task automatic t_out_double_hs;
    dbl_buf_en = 1; high_speed = 1;
    drive(1, 2, 0, 1, 0); expect_resp("R8 ack one free", 1, 1, 1);
    drive(1, 2, 0, 1, 0); expect_resp("R9 R8 nyet last slot", 3, 1, 2);
    drive(1, 2, 0, 1, 0); expect_resp("R9 nak two full", 2, 0, 2);
    drive(1, 2, 0, 1, 1); expect_resp("R12 full plus release", 2, 0, 1);
    drive(1, 2, 0, 1, 1); expect_resp("R8 accept plus release", 1, 1, 1);
    drive(0, 2, 0, 0, 1);
    dbl_buf_en = 0;
    drive(1, 3, 0, 1, 0); expect_resp("R8 single hs nyet", 3, 1, 1);
    drive(0, 2, 0, 0, 1); chk("R12 drain", r_lvl, 0);
    high_speed = 0;
  endtask

  task automatic t_bad_crc;
    drive(1, 2, 0, 0, 0); expect_resp("R5 bad crc", 0, 0, 0);
  endtask

  task automatic t_stall;
    stall_req = 1;
    drive(1, 2, 0, 1, 0); expect_resp("R2 stall out", 4, 0, 0);
    drive(1, 0, 0, 1, 0); expect_resp("R2 stall control", 4, 0, 0);
    stall_req = 0;
  endtask

  task automatic t_iso;
    drive(1, 1, 0, 1, 0); expect_resp("R4 iso out", 0, 1, 1);
    drive(0, 2, 0, 0, 1); chk("R4 drain", r_lvl, 0);
  endtask

  task automatic t_irq_off;
    int_en = 0;
    drive(1, 2, 0, 1, 0); expect_resp("R11 masked", 1, 0, 1);
    int_en = 1;
    drive(0, 2, 0, 0, 1); chk("R11 drain", r_lvl, 0);
  endtask

  task automatic t_ep0;
    drive(1, 0, 0, 1, 0);
    chk("R3 ep0 control not stalled", r0_code, 1);
    drive(0, 2, 0, 0, 1);
    drive(1, 2, 0, 1, 0);
    chk("R3 ep0 bulk stall", r0_code, 4);
    drive(0, 2, 0, 0, 1); chk("R3 drain", r_lvl, 0);
  endtask

  task automatic t_in;
    cfg_dir_in = 1; dbl_buf_en = 1;
    drive(1, 2, 1, 1, 0); expect_resp("R10 empty nak", 2, 0, 0);
    drive(1, 2, 0, 1, 0); expect_resp("R3 dir mismatch", 4, 0, 0);
    drive(0, 2, 1, 0, 1); chk("R12 load1", r_lvl, 1);
    drive(0, 2, 1, 0, 1); chk("R12 load2", r_lvl, 2);
    drive(0, 2, 1, 0, 1); chk("R12 load full ignored", r_lvl, 2);
    drive(1, 2, 1, 0, 0); expect_resp("R5 no host ack", 0, 0, 2);
    drive(1, 2, 1, 1, 0); expect_resp("R10 send", 1, 1, 1);
    drive(1, 3, 1, 1, 1); expect_resp("R12 send plus load", 1, 1, 1);
    drive(1, 2, 1, 1, 0); expect_resp("R10 send last", 1, 1, 0);
    drive(1, 1, 1, 1, 0); expect_resp("R4 iso in empty", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_out_single();
    t_out_double_hs();
    t_bad_crc();
    t_stall();
    t_iso();
    t_irq_off();
    t_ep0();
    t_in();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule